// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Pad Override

This block gathers every reset source of a telephony codec and line transceiver chip and turns them into pad overrides, a gated microcontroller clock and a reset output pin. There are three kinds of source. The first is an external hardware reset pin. The second is an undervoltage detector, which only counts when its enable input is set. The third is a set of software resets, one each for the serial-bus handler, the codec and the line transceiver. Each pad group has functional value and output-enable inputs, and the block passes them through to the pads. While a reset reaches a group, the block replaces them with that group's reset pattern.

The reset output pin covers hardware and undervoltage resets, and so do the control group's pads (serial-control data and interrupt). Both kinds of reset also reach every subsystem group. Assertion reaches the pads at once, with no clock edge. Release is timed in the reference-clock domain, after two-flop synchronisers. With undervoltage detection disabled, the release waits for a falling edge of the bit clock. With it enabled, the release waits a fixed 64 ms, counted in reference-clock cycles. The microcontroller clock output stops only while an undervoltage reset is in progress. The oscillator and the data clocks do not pass through this block and are never gated.

Top module: `rst_seq_top`

## Requirements
- R1: While `rst_ni` is low, `rst_o` is 1 and every pad group shows its reset pattern, as defined in R2 to R5.
- R2: The bus group has bit 0 = frame sync, bit 1 = strobe 1, bit 2 = bit clock, bit 3 = downstream data and bit 4 = upstream data. In reset it drives `bus_oe_o` = 5'b00011 and `bus_val_o` = 5'b00001. Outside reset both outputs equal their inputs. The bus group is in reset while `rst_o` is 1 or `sw_rst_bus_i` is 1.
- R3: The codec group is in reset while `rst_o` is 1 or `sw_rst_codec_i` is 1. In reset, `codec_oe_o` and `codec_val_o` are all zero. Outside reset both outputs equal their inputs.
- R4: The line group is in reset while `rst_o` is 1 or `sw_rst_line_i` is 1. In reset, `line_oe_o` and `line_val_o` are all zero. Outside reset both outputs equal their inputs.
- R5: The control group is in reset only while `rst_o` is 1. In reset, `ctl_oe_o` and `ctl_val_o` are zero. The software resets have no effect on it.
- R6: A software reset changes only its own group. It leaves `rst_o` at 0 and `mclk_o` equal to `mclk_i`.
- R7: When `ext_rst_ni` goes low, `rst_o` becomes 1 and the reset patterns of all groups appear with no reference-clock edge.
- R8: With `uv_en_i` = 0, `ext_rst_ni` is deasserted and a later bit-clock falling edge follows. `rst_o` is still 1 after two reference-clock rising edges from that falling edge and is 0 after the third. While the bit clock does not fall, `rst_o` stays 1.
- R9: With `uv_en_i` = 1, let T = 64·`CYC_PER_MS`. When the last of `ext_rst_ni` low and the undervoltage flag ends, `rst_o` is still 1 after T+1 reference-clock rising edges and is 0 after T+2. Bit-clock edges have no effect.
- R10: An undervoltage event during the countdown restarts it, so that R9 is timed from the end of the new event.
- R11: `mclk_o` is 0 while an undervoltage reset is in progress, including its countdown. At all other times, including during a hardware reset, `mclk_o` equals `mclk_i`.
- R12: With `uv_en_i` = 0, `uv_flag_i` has no effect: `rst_o` stays 0 and `mclk_o` follows `mclk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External hardware reset pin, active low |
| uv_flag_i | input | 1 | Undervoltage detector output, 1 = low supply |
| uv_en_i | input | 1 | Undervoltage detection enable |
| sw_rst_bus_i | input | 1 | Software reset of the serial-bus handler |
| sw_rst_codec_i | input | 1 | Software reset of the codec |
| sw_rst_line_i | input | 1 | Software reset of the line transceiver |
| bclk_i | input | 1 | Bit clock used for the release edge |
| mclk_i | input | 1 | Microcontroller clock source |
| bus_val_i | input | 5 | Functional bus pad values |
| bus_oe_i | input | 5 | Functional bus pad enables |
| codec_val_i | input | 4 | Functional codec output values |
| codec_oe_i | input | 4 | Functional codec output enables |
| line_val_i | input | 2 | Functional line-interface values |
| line_oe_i | input | 2 | Functional line-interface enables |
| ctl_val_i | input | 2 | Functional serial-control data / interrupt values |
| ctl_oe_i | input | 2 | Functional serial-control data / interrupt enables |
| bus_val_o | output | 5 | Bus pad values |
| bus_oe_o | output | 5 | Bus pad enables |
| codec_val_o | output | 4 | Codec pad values |
| codec_oe_o | output | 4 | Codec pad enables |
| line_val_o | output | 2 | Line pad values |
| line_oe_o | output | 2 | Line pad enables |
| ctl_val_o | output | 2 | Control pad values |
| ctl_oe_o | output | 2 | Control pad enables |
| mclk_o | output | 1 | Gated microcontroller clock |
| rst_o | output | 1 | Reset output pin, active high |

## Verification
A hold flag stuck at 1 keeps `rst_o` high and every group overridden indefinitely, and a stuck-at-0 flag frees the pads as soon as the raw source drops. Either shows at the first check after release. A countdown that runs from the wrong value, or that a new event does not clear, moves the `rst_o` falling edge away from the exact T+2 cycle. A lost undervoltage cause flag lets `mclk_o` run during the countdown. The bench sees each of these within one timeout window. A wrong group mapping shows at once in the combinational sweep over the software resets.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned BUS_W   = 5;
  localparam int unsigned CODEC_W = 4;
  localparam int unsigned LINE_W  = 2;
  localparam int unsigned CTL_W   = 2;

  // bus pin order: frame sync, strobe 1, bit clock, downstream, upstream
  localparam int unsigned BUS_FSC  = 0;
  localparam int unsigned BUS_STB1 = 1;

  localparam logic [BUS_W-1:0] BUS_FORCE_MASK = BUS_W'(1 << BUS_FSC) | BUS_W'(1 << BUS_STB1);
  localparam logic [BUS_W-1:0] BUS_FORCE_VAL  = BUS_W'(1 << BUS_FSC);

  typedef enum logic [1:0] {
    REL_IDLE  = 2'd0,
    REL_HOLD  = 2'd1,
    REL_COUNT = 2'd2,
    REL_EDGE  = 2'd3
  } rel_state_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_s_i,
  input  logic uv_s_i,
  input  logic uv_mode_i,
  input  logic bclk_s_i,
  output logic hold_o,
  output logic uv_cause_o,
  output rst_seq_pkg::rel_state_e state_o
);
  import rst_seq_pkg::*;

  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic             hold_q, cause_q, bclk_prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cond, bclk_fall;

  assign cond      = hw_s_i | uv_s_i;
  assign bclk_fall = bclk_prev_q & ~bclk_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b1;
    else         bclk_prev_q <= bclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= 1'b1;
      cause_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cond) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
      if (uv_s_i) cause_q <= 1'b1;
    end else if (hold_q) begin
      if (uv_mode_i) begin
        if (cnt_q == CNT_LAST) begin
          hold_q  <= 1'b0;
          cause_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (bclk_fall) begin
        hold_q  <= 1'b0;
        cause_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end

  always_comb begin
    if (!hold_q)        state_o = REL_IDLE;
    else if (cond)      state_o = REL_HOLD;
    else if (uv_mode_i) state_o = REL_COUNT;
    else                state_o = REL_EDGE;
  end

  assign hold_o     = hold_q;
  assign uv_cause_o = cause_q;
endmodule

// File: rtl/pad_group.sv
module pad_group #(
  parameter int unsigned W          = 2,
  parameter logic [W-1:0] FORCE_MASK = '0,
  parameter logic [W-1:0] FORCE_VAL  = '0
) (
  input  logic         in_rst_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] oe_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (FORCE_MASK[i]) begin : g_force
      assign oe_o[i]  = in_rst_i ? 1'b1 : oe_i[i];
      assign val_o[i] = in_rst_i ? FORCE_VAL[i] : val_i[i];
    end else begin : g_hiz
      assign oe_o[i]  = in_rst_i ? 1'b0 : oe_i[i];
      assign val_o[i] = in_rst_i ? 1'b0 : val_i[i];
    end
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_MS  = 7680,
  parameter int unsigned TIMEOUT_MS  = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_ni,
  input  logic               uv_flag_i,
  input  logic               uv_en_i,
  input  logic               sw_rst_bus_i,
  input  logic               sw_rst_codec_i,
  input  logic               sw_rst_line_i,
  input  logic               bclk_i,
  input  logic               mclk_i,
  input  logic [BUS_W-1:0]   bus_val_i,
  input  logic [BUS_W-1:0]   bus_oe_i,
  input  logic [CODEC_W-1:0] codec_val_i,
  input  logic [CODEC_W-1:0] codec_oe_i,
  input  logic [LINE_W-1:0]  line_val_i,
  input  logic [LINE_W-1:0]  line_oe_i,
  input  logic [CTL_W-1:0]   ctl_val_i,
  input  logic [CTL_W-1:0]   ctl_oe_i,
  output logic [BUS_W-1:0]   bus_val_o,
  output logic [BUS_W-1:0]   bus_oe_o,
  output logic [CODEC_W-1:0] codec_val_o,
  output logic [CODEC_W-1:0] codec_oe_o,
  output logic [LINE_W-1:0]  line_val_o,
  output logic [LINE_W-1:0]  line_oe_o,
  output logic [CTL_W-1:0]   ctl_val_o,
  output logic [CTL_W-1:0]   ctl_oe_o,
  output logic               mclk_o,
  output logic               rst_o
);
  localparam int unsigned TIMEOUT = TIMEOUT_MS * CYC_PER_MS;

  logic hw_raw, uv_raw, hw_s, uv_flag_s, bclk_s;
  logic hold, uv_cause, sys_rst, mclk_stop;
  rel_state_e rel_state;

  assign hw_raw = ~ext_rst_ni;
  assign uv_raw = uv_en_i & uv_flag_i;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hw (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hw_raw), .q_o(hw_s)
  );
  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_uv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(uv_flag_i), .q_o(uv_flag_s)
  );
  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bclk_i), .q_o(bclk_s)
  );

  rst_release #(.TIMEOUT(TIMEOUT)) u_release (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_s_i     (hw_s),
    .uv_s_i     (uv_flag_s & uv_en_i),
    .uv_mode_i  (uv_en_i),
    .bclk_s_i   (bclk_s),
    .hold_o     (hold),
    .uv_cause_o (uv_cause),
    .state_o    (rel_state)
  );

  // raw terms make assertion immediate; hold covers the release window
  assign sys_rst = ~rst_ni | hold | hw_raw | uv_raw;
  assign rst_o   = sys_rst;

  assign mclk_stop = uv_raw | uv_cause;
  assign mclk_o    = mclk_i & ~mclk_stop;

  pad_group #(.W(BUS_W), .FORCE_MASK(BUS_FORCE_MASK), .FORCE_VAL(BUS_FORCE_VAL)) u_pad_bus (
    .in_rst_i(sys_rst | sw_rst_bus_i),
    .val_i(bus_val_i), .oe_i(bus_oe_i), .val_o(bus_val_o), .oe_o(bus_oe_o)
  );
  pad_group #(.W(CODEC_W)) u_pad_codec (
    .in_rst_i(sys_rst | sw_rst_codec_i),
    .val_i(codec_val_i), .oe_i(codec_oe_i), .val_o(codec_val_o), .oe_o(codec_oe_o)
  );
  pad_group #(.W(LINE_W)) u_pad_line (
    .in_rst_i(sys_rst | sw_rst_line_i),
    .val_i(line_val_i), .oe_i(line_oe_i), .val_o(line_val_o), .oe_o(line_oe_o)
  );
  pad_group #(.W(CTL_W)) u_pad_ctl (
    .in_rst_i(sys_rst),
    .val_i(ctl_val_i), .oe_i(ctl_oe_i), .val_o(ctl_val_o), .oe_o(ctl_oe_o)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic       sw_rst_bus_i,
  input logic       sw_rst_codec_i,
  input logic       sw_rst_line_i,
  input logic       mclk_i,
  input logic [4:0] bus_val_o,
  input logic [4:0] bus_oe_o,
  input logic [3:0] codec_oe_o,
  input logic [1:0] line_oe_o,
  input logic [1:0] ctl_oe_o,
  input logic       mclk_o,
  input logic       rst_o
);
  // R7
  hw_drives_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |-> rst_o);
  // R2
  bus_pattern_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o || sw_rst_bus_i) |-> (bus_oe_o == 5'b00011 && bus_val_o[1:0] == 2'b01));
  // R3
  codec_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o || sw_rst_codec_i) |-> codec_oe_o == 4'b0);
  // R4
  line_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o || sw_rst_line_i) |-> line_oe_o == 2'b0);
  // R5
  ctl_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> ctl_oe_o == 2'b0);
  // R11
  mclk_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_o |-> mclk_o == mclk_i);
  // R1
  por_rst_chk: assert property (@(posedge clk_i)
    !rst_ni |-> rst_o);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
  .sw_rst_bus_i(sw_rst_bus_i), .sw_rst_codec_i(sw_rst_codec_i), .sw_rst_line_i(sw_rst_line_i),
  .mclk_i(mclk_i), .bus_val_o(bus_val_o), .bus_oe_o(bus_oe_o), .codec_oe_o(codec_oe_o),
  .line_oe_o(line_oe_o), .ctl_oe_o(ctl_oe_o), .mclk_o(mclk_o), .rst_o(rst_o)
);

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_PER_MS = 2;
  localparam int T = 64 * CYC_PER_MS;

  logic clk_i = 1'b0, rst_ni = 1'b0, ext_rst_ni = 1'b1, uv_flag_i = 1'b0, uv_en_i = 1'b0;
  logic sw_rst_bus_i = 1'b0, sw_rst_codec_i = 1'b0, sw_rst_line_i = 1'b0;
  logic bclk_i = 1'b1, mclk_i = 1'b1;
  logic [4:0] bus_val_i = '0, bus_oe_i = '0;
  logic [3:0] codec_val_i = '0, codec_oe_i = '0;
  logic [1:0] line_val_i = '0, line_oe_i = '0, ctl_val_i = '0, ctl_oe_i = '0;
  logic [4:0] bus_val_o, bus_oe_o;
  logic [3:0] codec_val_o, codec_oe_o;
  logic [1:0] line_val_o, line_oe_o, ctl_val_o, ctl_oe_o;
  logic mclk_o, rst_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rst_seq_top #(.CYC_PER_MS(CYC_PER_MS)) dut (.*);

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check_pads(string r, bit sys);
    bit b, c, l;
    b = sys | sw_rst_bus_i; c = sys | sw_rst_codec_i; l = sys | sw_rst_line_i;
    chk({r, " R2 bus_oe"},    8'(bus_oe_o),    b ? 8'h03 : 8'(bus_oe_i));
    chk({r, " R2 bus_val"},   8'(bus_val_o),   b ? 8'h01 : 8'(bus_val_i));
    chk({r, " R3 codec_oe"},  8'(codec_oe_o),  c ? 8'h00 : 8'(codec_oe_i));
    chk({r, " R3 codec_val"}, 8'(codec_val_o), c ? 8'h00 : 8'(codec_val_i));
    chk({r, " R4 line_oe"},   8'(line_oe_o),   l ? 8'h00 : 8'(line_oe_i));
    chk({r, " R4 line_val"},  8'(line_val_o),  l ? 8'h00 : 8'(line_val_i));
    chk({r, " R5 ctl_oe"},    8'(ctl_oe_o),    sys ? 8'h00 : 8'(ctl_oe_i));
    chk({r, " R5 ctl_val"},   8'(ctl_val_o),   sys ? 8'h00 : 8'(ctl_val_i));
  endtask

  task automatic set_func(int k);
    bus_val_i = 5'(k * 7 + 3); bus_oe_i = 5'(~(k * 5));
    codec_val_i = 4'(k + 9); codec_oe_i = 4'(k * 3 + 1);
    line_val_i = 2'(k); line_oe_i = 2'(~k);
    ctl_val_i = 2'(k + 1); ctl_oe_i = 2'(k + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    set_func(5);
    step(2);
    // R1 power-on state
    chk("R1 rst_o", 8'(rst_o), 8'h1);
    check_pads("R1", 1'b1);
    rst_ni = 1'b1;
    step(6);
    // R8 no bit-clock fall yet
    chk("R8 hold without bclk fall", 8'(rst_o), 8'h1);
    bclk_i = 1'b0;
    step(2);
    chk("R8 still held 2 edges after fall", 8'(rst_o), 8'h1);
    step(1);
    chk("R8 released 3rd edge", 8'(rst_o), 8'h0);
    bclk_i = 1'b1;
    step(3);

    // R6 software reset sweep
    for (int m = 0; m < 8; m++) begin
      sw_rst_bus_i = m[0]; sw_rst_codec_i = m[1]; sw_rst_line_i = m[2];
      set_func(m + 11);
      step(1); #1;
      check_pads("R6 sweep", 1'b0);
      chk("R6 rst_o stays low", 8'(rst_o), 8'h0);
      mclk_i = m[0];
      #1 chk("R6 mclk follows", 8'(mclk_o), 8'(m[0]));
    end
    sw_rst_bus_i = 0; sw_rst_codec_i = 0; sw_rst_line_i = 0; mclk_i = 1'b1;

    // R7 asynchronous hardware reset, sw resets mixed in
    step(1);
    sw_rst_codec_i = 1'b1;
    ext_rst_ni = 1'b0;
    #1;
    chk("R7 async rst_o", 8'(rst_o), 8'h1);
    check_pads("R7", 1'b1);
    chk("R11 mclk runs in hw reset", 8'(mclk_o), 8'h1);
    mclk_i = 1'b0;
    #1 chk("R11 mclk follows in hw reset", 8'(mclk_o), 8'h0);
    mclk_i = 1'b1;
    sw_rst_codec_i = 1'b0;
    step(4);
    ext_rst_ni = 1'b1;
    step(10);
    chk("R8 held after hw release", 8'(rst_o), 8'h1);
    bclk_i = 1'b0;
    step(2);
    chk("R8 held 2 edges", 8'(rst_o), 8'h1);
    step(1);
    chk("R8 released", 8'(rst_o), 8'h0);
    check_pads("R8 after release", 1'b0);
    bclk_i = 1'b1;

    // R12 flag ignored when disabled
    uv_flag_i = 1'b1;
    step(6);
    chk("R12 rst_o", 8'(rst_o), 8'h0);
    chk("R12 mclk", 8'(mclk_o), 8'h1);
    check_pads("R12", 1'b0);
    uv_flag_i = 1'b0;
    step(3);

    // R9 undervoltage timeout
    uv_en_i = 1'b1;
    step(3);
    chk("R9 enable alone no reset", 8'(rst_o), 8'h0);
    uv_flag_i = 1'b1;
    #1;
    chk("R9 async uv rst_o", 8'(rst_o), 8'h1);
    chk("R11 mclk stopped", 8'(mclk_o), 8'h0);
    check_pads("R9", 1'b1);
    step(5);
    uv_flag_i = 1'b0;
    step(10);
    bclk_i = 1'b0;
    step(T - 9);
    chk("R9 held at T+1", 8'(rst_o), 8'h1);
    chk("R11 mclk stopped countdown", 8'(mclk_o), 8'h0);
    step(1);
    chk("R9 released at T+2", 8'(rst_o), 8'h0);
    chk("R11 mclk resumes", 8'(mclk_o), 8'h1);
    bclk_i = 1'b1;
    step(3);

    // R10 restart on new event
    uv_flag_i = 1'b1; step(3); uv_flag_i = 1'b0;
    step(50);
    uv_flag_i = 1'b1; step(3); uv_flag_i = 1'b0;
    step(T + 1);
    chk("R10 held after restart", 8'(rst_o), 8'h1);
    chk("R10 mclk stopped", 8'(mclk_o), 8'h0);
    step(1);
    chk("R10 released", 8'(rst_o), 8'h0);
    step(3);

    // R9/R11 hardware reset in timeout mode
    ext_rst_ni = 1'b0; step(3); ext_rst_ni = 1'b1;
    step(T + 1);
    chk("R9 hw held T+1", 8'(rst_o), 8'h1);
    chk("R11 mclk runs hw in uv mode", 8'(mclk_o), 8'h1);
    check_pads("R9 hw", 1'b1);
    step(1);
    chk("R9 hw released T+2", 8'(rst_o), 8'h0);
    check_pads("R9 hw after", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule